// File: doc/BRIEF.md
# Bit-Serial Processing Element Register Array

This block holds the per-element state of a word-parallel, bit-serial processor. It has N identical processing elements. Each element owns one bit of three registers: a mask register, an accumulator X and a second register Y. A single broadcast operation is applied to all elements at once. The operation combines each element's register bit with the matching bit of an N-bit input vector. The combining function is any of the sixteen Boolean functions of two inputs, chosen by a 4-bit truth table.

Several modes decide which registers take part. X and Y can be updated on their own or together. X can also be updated only in the elements whose Y bit is set. In the last such mode, Y is updated in the same cycle and X is gated by the value Y held before that edge. The mask register loads from the input vector and is brought out as a write mask for an array memory. X and Y are brought out for the data path and for feedback. An outside sequencer streams bit-slices through these operations to carry out arithmetic in all elements at once, for example a field add that keeps the carry in Y.

Top module: `pe_reg_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the mask register, X and Y to all zeros.
- R2: The function result for register bit r and input bit f is `opFunc[2*r+f]`. Mode 3'b000 sets each X bit to that result and leaves Y and the mask unchanged.
- R3: Mode 3'b001 sets each Y bit to the function of (Y bit, input bit) and leaves X and the mask unchanged.
- R4: Mode 3'b010 applies the same function to X and to Y in the same cycle, each register using its own bits. The mask is unchanged.
- R5: Mode 3'b011 updates X only in elements where Y is 1, and holds X where Y is 0. Y and the mask are unchanged.
- R6: Mode 3'b100 updates Y with the function, and updates X with the function only where the Y bit before the edge was 1. The mask is unchanged.
- R7: Mode 3'b101 loads the mask register from `fIn` and leaves X and Y unchanged.
- R8: When `opEn` is low, or when the mode is 3'b110 or 3'b111, no register changes.
- R9: Every update appears on `mOut`, `xOut` and `yOut` after exactly one rising edge. A field add can be run as follows, starting with Y holding the carry and X zero: mode 100 XOR with slice a, then mode 100 XOR with slice b. After these two steps Y holds the sum slice. Then mode 000 XOR with f = Y, then mode 010 XOR with f = X. After these steps X is zero and Y holds the carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opEn | input | 1 | Qualifies the operation in this cycle |
| opMode | input | 3 | Selects the operation mode |
| opFunc | input | 4 | Truth table of the two-input function |
| fIn | input | N | Broadcast input vector, one bit per element |
| mOut | output | N | Mask register, used as the memory write mask |
| xOut | output | N | X register |
| yOut | output | N | Y register |

## Verification
The properties assume that `opMode`, `opEn` and `fIn` are stable around each rising edge. They also assume that reset is held high from time zero for at least one edge, so every past value they compare against was formed after reset. The bench drives every input on the falling edge and holds it for a full cycle. It asserts reset before any operation and feeds back `xOut` and `yOut` only after they have settled. This keeps the field-add sequence, whose input depends on the registers, inside those assumptions.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    MODE_X          = 3'd0,
    MODE_Y          = 3'd1,
    MODE_XY         = 3'd2,
    MODE_XMASK      = 3'd3,
    MODE_XMASK_YUPD = 3'd4,
    MODE_LOADM      = 3'd5
  } peMode_t;

  typedef struct packed {
    logic wrX;
    logic wrY;
    logic wrM;
    logic maskX;
  } peStrobe_t;
endpackage

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
(
  input  logic       opEn,
  input  logic [2:0] opMode,
  output peStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    if (opEn) begin
      case (opMode)
        MODE_X:          strobe.wrX = 1'b1;
        MODE_Y:          strobe.wrY = 1'b1;
        MODE_XY:         begin strobe.wrX = 1'b1; strobe.wrY = 1'b1; end
        MODE_XMASK:      begin strobe.wrX = 1'b1; strobe.maskX = 1'b1; end
        MODE_XMASK_YUPD: begin strobe.wrX = 1'b1; strobe.wrY = 1'b1; strobe.maskX = 1'b1; end
        MODE_LOADM:      strobe.wrM = 1'b1;
        default:         strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  peStrobe_t    strobe,
  input  logic [3:0]   opFunc,
  input  logic [N-1:0] fIn,
  output logic [N-1:0] mReg,
  output logic [N-1:0] xReg,
  output logic [N-1:0] yReg
);
  logic [N-1:0] xNew, yNew, xWe;

  for (genvar i = 0; i < N; i++) begin : g_pe
    assign xNew[i] = opFunc[{xReg[i], fIn[i]}];
    assign yNew[i] = opFunc[{yReg[i], fIn[i]}];
    assign xWe[i]  = strobe.wrX & (~strobe.maskX | yReg[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mReg <= '0;
      xReg <= '0;
      yReg <= '0;
    end else begin
      if (strobe.wrM) mReg <= fIn;
      if (strobe.wrY) yReg <= yNew;
      xReg <= (xNew & xWe) | (xReg & ~xWe);
    end
  end
endmodule

// File: rtl/pe_reg_array.sv
module pe_reg_array
  import pe_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opEn,
  input  logic [2:0]   opMode,
  input  logic [3:0]   opFunc,
  input  logic [N-1:0] fIn,
  output logic [N-1:0] mOut,
  output logic [N-1:0] xOut,
  output logic [N-1:0] yOut
);
  peStrobe_t strobe;

  pe_ctrl i_ctrl (
    .opEn   (opEn),
    .opMode (opMode),
    .strobe (strobe)
  );

  pe_datapath #(.N(N)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opFunc (opFunc),
    .fIn    (fIn),
    .mReg   (mOut),
    .xReg   (xOut),
    .yReg   (yOut)
  );
endmodule

// File: rtl/pe_reg_array_chk.sv
module pe_reg_array_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         opEn,
  input logic [2:0]   opMode,
  input logic [N-1:0] fIn,
  input logic [N-1:0] mOut,
  input logic [N-1:0] xOut,
  input logic [N-1:0] yOut
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (mOut == '0 && xOut == '0 && yOut == '0)); // R1

  AST_XONLY_HOLDS_YM: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 3'd0) |=> ($stable(yOut) && $stable(mOut))); // R2

  AST_YONLY_HOLDS_XM: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 3'd1) |=> ($stable(xOut) && $stable(mOut))); // R3

  AST_XMASK_GATED: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 3'd3) |=> ($stable(yOut) && $stable(mOut) &&
      ((xOut & ~yOut) == ($past(xOut) & ~yOut)))); // R5

  AST_OLDY_GATES_X: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 3'd4) |=> ($stable(mOut) &&
      ((xOut & ~$past(yOut)) == ($past(xOut) & ~$past(yOut))))); // R6

  AST_LOADM: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 3'd5) |=> (mOut == $past(fIn) && $stable(xOut) && $stable(yOut))); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!opEn || opMode == 3'd6 || opMode == 3'd7) |=>
      ($stable(mOut) && $stable(xOut) && $stable(yOut))); // R8
endmodule

bind pe_reg_array pe_reg_array_chk #(.N(N)) i_chk (
  .clk(clk), .rst(rst), .opEn(opEn), .opMode(opMode), .fIn(fIn),
  .mOut(mOut), .xOut(xOut), .yOut(yOut)
);

// File: tb/test_pe_reg_array.sv
module test_pe_reg_array;
  localparam int N  = 16;
  localparam int NB = 8;
  localparam logic [3:0] F_XOR = 4'b0110;
  localparam logic [3:0] F_AND = 4'b1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opEn = 1'b0;
  logic [2:0] opMode = '0;
  logic [3:0] opFunc = '0;
  logic [N-1:0] fIn = '0;
  logic [N-1:0] mOut, xOut, yOut;
  logic [N-1:0] expM = '0, expX = '0, expY = '0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pe_reg_array #(.N(N)) i_pe_reg_array (
    .clk(clk), .rst(rst), .opEn(opEn), .opMode(opMode), .opFunc(opFunc),
    .fIn(fIn), .mOut(mOut), .xOut(xOut), .yOut(yOut)
  );

  task automatic checkVec(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    checkVec(req, "M", mOut, expM);
    checkVec(req, "X", xOut, expX);
    checkVec(req, "Y", yOut, expY);
  endtask

  // Drive one operation, update the shadow model, check after the edge.
  task automatic doOp(string req, logic en, logic [2:0] mode, logic [3:0] fn, logic [N-1:0] f);
    logic [N-1:0] nx, ny;
    @(negedge clk);
    opEn = en; opMode = mode; opFunc = fn; fIn = f;
    nx = expX; ny = expY;
    for (int i = 0; i < N; i++) begin
      logic px, py;
      px = fn[{expX[i], f[i]}];
      py = fn[{expY[i], f[i]}];
      if (en) begin
        case (mode)
          3'd0: nx[i] = px;
          3'd1: ny[i] = py;
          3'd2: begin nx[i] = px; ny[i] = py; end
          3'd3: if (expY[i]) nx[i] = px;
          3'd4: begin if (expY[i]) nx[i] = px; ny[i] = py; end
          default: ;
        endcase
      end
    end
    if (en && mode == 3'd5) expM = f;
    expX = nx; expY = ny;
    @(negedge clk);
    opEn = 1'b0;
    checkAll(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expM = '0; expX = '0; expY = '0;
    checkAll("R1");
  endtask

  task automatic testReset();
    doOp("R7", 1'b1, 3'd5, 4'h0, 16'hFFFF);
    doOp("R3", 1'b1, 3'd1, 4'b1111, 16'h0000);
    doOp("R2", 1'b1, 3'd0, 4'b1111, 16'h0000);
    doReset();
  endtask

  task automatic testSingle();
    doOp("R2", 1'b1, 3'd0, F_XOR, 16'hA5C3);
    doOp("R2", 1'b1, 3'd0, F_AND, 16'hFF00);
    doOp("R2", 1'b1, 3'd0, 4'b1101, 16'h0F0F);
    doOp("R3", 1'b1, 3'd1, 4'b1110, 16'h3C3C);
    doOp("R3", 1'b1, 3'd1, 4'b0101, 16'h1234);
  endtask

  task automatic testBoth();
    doOp("R4", 1'b1, 3'd2, F_XOR, 16'h5A5A);
    doOp("R4", 1'b1, 3'd2, 4'b0010, 16'hF0F0);
  endtask

  task automatic testMasked();
    doOp("R3", 1'b1, 3'd1, 4'b1100, 16'h0000);
    doOp("R3", 1'b1, 3'd1, 4'b1010, 16'h00FF);
    doOp("R5", 1'b1, 3'd3, 4'b1111, 16'h0000);
    doOp("R5", 1'b1, 3'd3, F_XOR, 16'hFFFF);
    doOp("R6", 1'b1, 3'd4, F_XOR, 16'h0F0F);
    doOp("R6", 1'b1, 3'd4, 4'b0011, 16'h8001);
  endtask

  task automatic testLoadIdle();
    doOp("R7", 1'b1, 3'd5, 4'b1111, 16'hBEEF);
    doOp("R8", 1'b0, 3'd2, 4'b0011, 16'h1357);
    doOp("R8", 1'b1, 3'd6, 4'b0011, 16'hFFFF);
    doOp("R8", 1'b1, 3'd7, 4'b1111, 16'h0000);
  endtask

  task automatic testFieldAdd(int seed);
    logic [NB-1:0] a [N];
    logic [NB-1:0] b [N];
    logic [NB:0] sum [N];
    logic [N-1:0] aS, bS, sS, cS;
    int s;
    s = seed;
    doReset();
    for (int e = 0; e < N; e++) begin
      a[e] = NB'($urandom(s + e));
      b[e] = NB'($urandom(s + 100 + e));
      if (e == 0) begin a[e] = '1; b[e] = '1; end
      if (e == 1) begin a[e] = '1; b[e] = NB'(1); end
      if (e == 2) begin a[e] = '0; b[e] = '0; end
      sum[e] = {1'b0, a[e]} + {1'b0, b[e]};
    end
    for (int k = 0; k < NB; k++) begin
      for (int e = 0; e < N; e++) begin
        aS[e] = a[e][k]; bS[e] = b[e][k]; sS[e] = sum[e][k];
      end
      doOp("R9", 1'b1, 3'd4, F_XOR, aS);
      doOp("R9", 1'b1, 3'd4, F_XOR, bS);
      checkVec("R9", "sum slice", yOut, sS);
      doOp("R9", 1'b1, 3'd0, F_XOR, yOut);
      doOp("R9", 1'b1, 3'd2, F_XOR, xOut);
    end
    for (int e = 0; e < N; e++) cS[e] = sum[e][NB];
    checkVec("R9", "carry out", yOut, cS);
    checkVec("R9", "X cleared", xOut, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkAll("R1");
    testSingle();
    testBoth();
    testMasked();
    testLoadIdle();
    testReset();
    testFieldAdd(7);
    testFieldAdd(91);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule